// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit multiplication and division one bit per cycle. Each command can be signed or unsigned. It writes every result into a private pair of registers called HI and LO. A multiply leaves the 64-bit product split across the pair, with the upper word in HI and the lower word in LO. A divide leaves the quotient in LO and the remainder in HI. A read port returns HI or LO, as the requester chooses, in the same way as a move-from instruction.

A command is accepted only while the unit is idle. An accepted command runs in three phases:

- one setup cycle, which latches the operand magnitudes;
- WIDTH shift-and-add or shift-and-subtract cycles;
- one write-back cycle, which fixes the signs and updates HI/LO.

The `busy` output is high during all three phases. A read requested while `busy` is high raises `stall` until the new result has been written. The previous HI/LO contents stay on the read port until the write-back.

Signed commands run on the operand magnitudes and correct the signs at the end. A divisor of zero does not trap. It produces a fixed result.

Top module: `muldiv_hilo`

## Requirements
- R1: Command code 2'b00 (unsigned multiply) leaves HI:LO equal to the 64-bit unsigned product of the operands, with HI holding the upper word.
- R2: Command code 2'b01 (signed multiply) leaves HI:LO equal to the 64-bit two's-complement product of the operands.
- R3: Command code 2'b10 (unsigned divide) with a non-zero divisor leaves the quotient in LO and the remainder in HI.
- R4: Command code 2'b11 (signed divide) with a non-zero divisor leaves in LO the quotient truncated toward zero, and in HI a remainder that carries the dividend's sign. The case 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R5: A divide of either signedness by zero leaves LO all ones and HI equal to the dividend.
- R6: `busy` rises in the cycle after a command is accepted. It stays high for exactly WIDTH+2 cycles.
- R7: A `cmd_valid` pulse while `busy` is high is ignored. The result is that of the running command.
- R8: While a command runs, the read port keeps returning the HI/LO values from before that command.
- R9: `stall` is high exactly when `rd_req` is high and the unit is busy.
- R10: `rd_sel` = 1 returns HI on `rd_data` and `rd_sel` = 0 returns LO, combinationally.
- R11: After reset, HI and LO read as zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 00 mul unsigned, 01 mul signed, 10 div unsigned, 11 div signed |
| cmd_a | input | WIDTH | Multiplicand or dividend |
| cmd_b | input | WIDTH | Multiplier or divisor |
| rd_req | input | 1 | Read of HI or LO requested |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_data | output | WIDTH | Selected HI or LO contents |
| busy | output | 1 | Command in progress |
| stall | output | 1 | Read must wait for the running command |

## Verification
The bench builds the unit at the default WIDTH of 32. At that width the reference functions map directly onto 64-bit bench arithmetic, so every product and every quotient/remainder pair is compared in full. The full-scale corners are all in reach: the most negative value, all-ones operands, the 0x80000000 / -1 overflow case, and both signed and unsigned division by zero. The run length of 34 busy cycles is counted at the ports on every command.

// File: rtl/muldiv_pkg.sv
// Package: shared command and state encodings for the multiply/divide unit.
// Assumes: bit 1 of a command selects divide, bit 0 selects signed.
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULU = 2'b00,
        OP_MULS = 2'b01,
        OP_DIVU = 2'b10,
        OP_DIVS = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SETUP = 2'b01,
        ST_ITER  = 2'b10,
        ST_WRITE = 2'b11
    } md_state_e;

endpackage

// File: rtl/md_operand_prep.sv
// Module: md_operand_prep
// Converts one operand to magnitude form and reports its sign.
// Assumes: for unsigned commands the value passes through unchanged; the
// most negative signed value maps to 2**(W-1), which still fits in W bits.
module md_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic         signed_en,
    output logic [W-1:0] mag,
    output logic         neg
);

    // Sign detection and conditional two's-complement negation.
    always_comb begin
        neg = signed_en & val[W-1];
        mag = neg ? (~val + {{(W-1){1'b0}}, 1'b1}) : val;
    end

endmodule

// File: rtl/md_mul_iter.sv
// Module: md_mul_iter
// Shift-add unsigned multiplier: one multiplier bit per step, W steps.
// Assumes: load and step are never asserted together; the product is
// valid after exactly W steps following a load.
module md_mul_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] product
);

    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] acc_q;
    logic [W:0]     upper_sum;

    // Conditional add of the multiplicand into the upper half, with carry.
    always_comb begin
        upper_sum = {1'b0, acc_q[2*W-1:W]};
        if (acc_q[0]) begin
            upper_sum = {1'b0, acc_q[2*W-1:W]} + {1'b0, mcand_q};
        end
    end

    // Accumulator: load the multiplier low, then shift right once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            acc_q   <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            acc_q   <= {upper_sum, acc_q[W-1:1]};
        end
    end

    assign product = acc_q;

    // Guard: the controller must never ask for a load and a step at once.
    p_no_load_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

    // R1: a loaded zero multiplier keeps the upper half at zero on the first step.
    p_zero_mplier_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mplier_in == '0) |=> (acc_q == '0));

endmodule

// File: rtl/md_div_iter.sv
// Module: md_div_iter
// Restoring unsigned divider: one quotient bit per step, W steps.
// Assumes: load and step are exclusive. A zero divisor needs no special
// case: every trial subtract succeeds, so the quotient becomes all ones
// and the remainder ends equal to the dividend.
module md_div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend_in,
    input  logic [W-1:0] divisor_in,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);

    logic [W-1:0] dvsr_q;
    logic [W-1:0] quo_q;
    logic [W:0]   rem_q;
    logic [W:0]   shifted;
    logic [W+1:0] trial;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        trial   = {1'b0, shifted} - {2'b00, dvsr_q};
    end

    // Partial remainder and quotient registers; restore when the trial borrows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvsr_q <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
        end else if (load) begin
            dvsr_q <= divisor_in;
            quo_q  <= dividend_in;
            rem_q  <= '0;
        end else if (step) begin
            if (!trial[W+1]) begin
                rem_q <= trial[W:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted;
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q[W-1:0];

    // R3: the partial remainder never reaches the divisor after a step.
    p_rem_below_dvsr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step) && dvsr_q != '0) |-> (rem_q < {1'b0, dvsr_q}));

    // R5: with a zero divisor every step shifts in a one.
    p_zero_dvsr_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dvsr_q == '0) |=> quo_q[0]);

endmodule

// File: rtl/muldiv_hilo.sv
// Module: muldiv_hilo (top)
// Iterative multiply/divide unit with a HI/LO result pair and a read port.
// Sequence: accept -> setup (magnitudes into the core) -> W iterations ->
// write-back (sign fix, HI/LO update) -> idle. busy covers W+2 cycles.
// Assumes: a requester holds a read while stall is high; commands arriving
// while busy are dropped.
module muldiv_hilo #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_a,
    input  logic [WIDTH-1:0] cmd_b,
    input  logic             rd_req,
    input  logic             rd_sel,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             stall
);
    import muldiv_pkg::*;

    localparam int CW   = $clog2(WIDTH + 1);
    localparam int RW   = $clog2(WIDTH + 3) + 1;
    localparam int NOPS = 2;

    md_state_e        state_q;
    md_op_e           op_q;
    logic [WIDTH-1:0] a_q, b_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH-1:0] hi_q, lo_q;

    logic             is_div, is_signed, b_zero;
    logic [WIDTH-1:0] opnd_val [NOPS];
    logic [WIDTH-1:0] opnd_mag [NOPS];
    logic             opnd_neg [NOPS];
    logic             core_load, core_step;
    logic [2*WIDTH-1:0] product, prod_fix;
    logic [WIDTH-1:0] quo, rem, quo_fix, rem_fix;
    logic [WIDTH-1:0] hi_next, lo_next;

    assign is_div    = op_q[1];
    assign is_signed = op_q[0];
    assign b_zero    = (b_q == '0);
    assign opnd_val[0] = a_q;
    assign opnd_val[1] = b_q;

    // One magnitude/sign converter per operand.
    for (genvar gi = 0; gi < NOPS; gi++) begin : g_prep
        md_operand_prep #(.W(WIDTH)) u_prep (
            .val       (opnd_val[gi]),
            .signed_en (is_signed),
            .mag       (opnd_mag[gi]),
            .neg       (opnd_neg[gi])
        );
    end

    assign core_load = (state_q == ST_SETUP);
    assign core_step = (state_q == ST_ITER);

    md_mul_iter #(.W(WIDTH)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (core_load & ~is_div),
        .step      (core_step & ~is_div),
        .mcand_in  (opnd_mag[0]),
        .mplier_in (opnd_mag[1]),
        .product   (product)
    );

    md_div_iter #(.W(WIDTH)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (core_load & is_div),
        .step        (core_step & is_div),
        .dividend_in (opnd_mag[0]),
        .divisor_in  (opnd_mag[1]),
        .quotient    (quo),
        .remainder   (rem)
    );

    // Sign correction and choice of the value pair written into HI/LO.
    always_comb begin
        prod_fix = (opnd_neg[0] ^ opnd_neg[1]) ? (~product + 1'b1) : product;
        quo_fix  = (opnd_neg[0] ^ opnd_neg[1]) ? (~quo + 1'b1) : quo;
        rem_fix  = opnd_neg[0] ? (~rem + 1'b1) : rem;
        if (!is_div) begin
            hi_next = prod_fix[2*WIDTH-1:WIDTH];
            lo_next = prod_fix[WIDTH-1:0];
        end else if (b_zero) begin
            hi_next = a_q;
            lo_next = '1;
        end else begin
            hi_next = rem_fix;
            lo_next = quo_fix;
        end
    end

    // Sequencer: accept, setup, iterate WIDTH times, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_MULU;
            a_q     <= '0;
            b_q     <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= md_op_e'(cmd_op);
                        a_q     <= cmd_a;
                        b_q     <= cmd_b;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt_q   <= '0;
                    state_q <= ST_ITER;
                end
                ST_ITER: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(WIDTH - 1)) begin
                        state_q <= ST_WRITE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // HI/LO pair: cleared by reset, written only in the write-back cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (state_q == ST_WRITE) begin
            hi_q <= hi_next;
            lo_q <= lo_next;
        end
    end

    // Read port and handshake outputs.
    assign busy    = (state_q != ST_IDLE);
    assign stall   = rd_req & busy;
    assign rd_data = rd_sel ? hi_q : lo_q;

    // Run-length counter used only by the latency assertion.
    logic [RW-1:0] busy_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else begin
            busy_run <= busy ? busy_run + 1'b1 : '0;
        end
    end

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == RW'(WIDTH + 2)));

    p_ignore_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(op_q) && $stable(a_q) && $stable(b_q)));

    p_hilo_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

    p_no_stall_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !stall);

    p_div_zero_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && is_div && b_zero) |=> (lo_q == '1 && hi_q == $past(a_q)));

endmodule

// File: tb/tb_muldiv_hilo.sv
// Bench for muldiv_hilo: directed corners plus seeded random commands,
// compared against reference results computed with 64-bit arithmetic.
module tb_muldiv_hilo;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'b00;
    logic [W-1:0] cmd_a = '0;
    logic [W-1:0] cmd_b = '0;
    logic         rd_req = 1'b0;
    logic         rd_sel = 1'b0;
    logic [W-1:0] rd_data;
    logic         busy;
    logic         stall;

    int n_vec = 0;
    int n_bad = 0;
    logic [W-1:0] prev_hi = '0;
    logic [W-1:0] prev_lo = '0;

    muldiv_hilo #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .rd_req(rd_req), .rd_sel(rd_sel),
        .rd_data(rd_data), .busy(busy), .stall(stall)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_calc(input logic [1:0] op, input logic [31:0] a,
                                             input logic [31:0] b);
        logic signed [63:0] sp;
        logic signed [31:0] sq, sr;
        logic [63:0] r;
        case (op)
            2'b00: r = {32'd0, a} * {32'd0, b};
            2'b01: begin
                sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
                r = sp;
            end
            2'b10: r = (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b};
            default: begin
                if (b == 0) r = {a, 32'hFFFF_FFFF};
                else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) r = {32'd0, 32'h8000_0000};
                else begin
                    sq = $signed(a) / $signed(b);
                    sr = $signed(a) % $signed(b);
                    r = {sr, sq};
                end
            end
        endcase
        return r;
    endfunction

    function automatic string op_tag(input logic [1:0] op, input logic [31:0] b);
        if (op[1] && b == 0) return "R5";
        case (op)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Read HI and LO through the port (R10) away from the clock edge.
    task automatic read_pair(output logic [W-1:0] hi, output logic [W-1:0] lo);
        rd_sel = 1'b1; #1; hi = rd_data;
        rd_sel = 1'b0; #1; lo = rd_data;
    endtask

    // Issue a command; optionally pulse a second command while busy (R7).
    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input bit intrude);
        int blen;
        logic [W-1:0] hi, lo;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R6 busy rise", {63'd0, busy}, 64'd1);
        rd_req = 1'b1; #1;
        check("R9 stall busy", {63'd0, stall}, 64'd1);
        read_pair(hi, lo);
        check("R8 old value", {hi, lo}, {prev_hi, prev_lo});
        rd_req = 1'b0;
        if (intrude) begin
            cmd_valid = 1'b1; cmd_op = ~op; cmd_a = ~a; cmd_b = b + 1;
        end
        blen = 0;
        while (busy) begin
            blen++;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        check("R6 busy length", 64'(blen), 64'(W + 2));
        rd_req = 1'b1; #1;
        check("R9 stall idle", {63'd0, stall}, 64'd0);
        rd_req = 1'b0;
        read_pair(hi, lo);
        check(intrude ? "R7 ignore" : op_tag(op, b), {hi, lo}, ref_calc(op, a, b));
        prev_hi = hi; prev_lo = lo;
    endtask

    initial begin : watchdog
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] hi, lo;
        logic [31:0] ra, rb;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_pair(hi, lo);
        check("R11 reset hilo", {hi, lo}, 64'd0);
        check("R11 reset busy", {63'd0, busy}, 64'd0);
        // R10: the read port selects correctly after a known result.
        run_op(2'b00, 32'h0001_0000, 32'h0003_0000, 1'b0);
        rd_sel = 1'b1; #1; check("R10 hi sel", {32'd0, rd_data}, 64'd3);
        rd_sel = 1'b0; #1; check("R10 lo sel", {32'd0, rd_data}, 64'd0);
        // Directed corners.
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op(2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0);
        run_op(2'b01, 32'hFFFF_FFFF, 32'h0000_0007, 1'b0);
        run_op(2'b01, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
        run_op(2'b10, 32'hFFFF_FFFF, 32'h0000_0010, 1'b0);
        run_op(2'b10, 32'd5, 32'd9, 1'b0);
        run_op(2'b11, 32'hFFFF_FFF9, 32'd2, 1'b0);
        run_op(2'b11, 32'd7, 32'hFFFF_FFFE, 1'b0);
        run_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op(2'b10, 32'h1234_5678, 32'd0, 1'b0);
        run_op(2'b11, 32'hDEAD_BEEF, 32'd0, 1'b0);
        run_op(2'b01, 32'd0, 32'hFFFF_FFFF, 1'b0);
        run_op(2'b11, 32'h0BAD_F00D, 32'h0000_0123, 1'b1);
        run_op(2'b00, 32'h0000_1111, 32'h0000_2222, 1'b1);
        // Seeded random commands, with small divisors mixed in.
        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            rb = $urandom;
            if (($urandom % 4) == 0) rb = $urandom % 300;
            if (($urandom % 8) == 0) ra = $urandom % 1000;
            run_op(2'($urandom % 4), ra, rb, (($urandom % 10) == 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule